// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates one 32-bit virtual address at a time into a physical address. It reads one or two 32-bit descriptors from an in-memory table through a request/response port that allows one outstanding read. The first-level descriptor either maps a 1 MB section directly or points to a coarse or fine second-level table. The second-level descriptor maps a 64 KB, 4 KB or 1 KB page.

Each first-level descriptor names one of sixteen domains. A 32-bit domain control word gives each domain a two-bit mode. Depending on that mode, the domain blocks the access, checks the page permission, or allows every access. When a translation is refused, the block reports a fault kind, the table level at which it stopped, and the domain.

A caller raises `start` for one cycle while the block is idle. The block then holds `busy` high and raises `done` for one cycle when the result is ready.

Top module: `pgwalk_top`

## Requirements
- R1: A `start` pulse while idle latches `va`, `acc`, `is_user`, `ttb`, `dacr` and `ext_page_en`, and begins a walk. `busy` stays high from the next cycle up to and including the single cycle in which `done` is high. A `start` while busy is ignored and does not change the result.
- R2: The first read goes to `{ttb[31:14], va[31:20], 2'b00}`. The request address stays stable while `mem_req_valid` is high and `mem_req_ready` is low. Only one read is in flight at a time.
- R3: First-level descriptor bits [1:0] select the entry. Value 0 is a translation fault at level 1. Value 1 points to a coarse table, value 2 is a section, and value 3 points to a fine table.
- R4: The domain number d is descriptor bits [8:5], and its mode is `dacr[2d+1:2d]`. Mode 0 or 2 gives a domain fault that reports domain d, with no second-level read. The level is 1 for a section and 2 for a table.
- R5: A section maps to `{desc[31:20], va[19:0]}` with page size code 3. Its permission field is desc[11:10].
- R6: The second-level read address is `{desc[31:10], va[19:12], 2'b00}` for a coarse table and `{desc[31:12], va[19:10], 2'b00}` for a fine table.
- R7: A second-level entry of type 1 is a 64 KB page. It maps to `{desc[31:16], va[15:0]}` with size code 2. Its permission field is at bit 4 + 2·va[15:14].
- R8: A second-level entry of type 2 is a 4 KB page. It maps to `{desc[31:12], va[11:0]}` with size code 1. Its permission field is at bit 4 + 2·va[11:10].
- R9: A second-level entry of type 3 has its permission field at desc[5:4]. Reached through a fine table, it is a 1 KB page, `{desc[31:10], va[9:0]}`, size code 0. Reached through a coarse table, it is a 4 KB page, `{desc[31:12], va[11:0]}`, when `ext_page_en` is 1. When `ext_page_en` is 0 it is a translation fault at level 2.
- R10: A second-level entry of type 0 gives a translation fault at level 2 and reports the table's domain.
- R11: Domain mode 3 allows every access. Domain mode 1 applies the permission field: 0 gives no access; 1 gives read/write when privileged and nothing for user; 2 gives read/write when privileged and read only for user; 3 gives read/write for both. Fetch is allowed when read or write is allowed. `acc` encodes 0 = read, 1 = write, 2 or 3 = fetch. A refused access gives a permission fault at level 1 for a section and level 2 for a page.
- R12: An error response (`mem_rsp_err`) gives an external-abort fault. It reports level 1 with domain 0 on the first read, and level 2 with the table's domain on the second read.
- R13: `fault_kind` encodes 0 = none, 1 = translation, 2 = domain, 3 = permission, 4 = external abort. `fault` is high when `fault_kind` is nonzero. On a fault, `pa` and `page_sz` read 0. On success, `fault_lvl` and `fault_dom` read 0. All outputs hold until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk when idle |
| va | input | 32 | Virtual address |
| acc | input | 2 | Access type: 0 read, 1 write, 2/3 fetch |
| is_user | input | 1 | Unprivileged access |
| ttb | input | 32 | First-level table base, bits [31:14] used |
| dacr | input | 32 | Sixteen two-bit domain modes |
| ext_page_en | input | 1 | Allow 4 KB type-3 entries in coarse tables |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| pa | output | 32 | Physical address |
| page_sz | output | 2 | 0: 1 KB, 1: 4 KB, 2: 64 KB, 3: 1 MB |
| fault | output | 1 | Translation refused |
| fault_kind | output | 3 | Fault kind code |
| fault_lvl | output | 2 | Level at which the walk stopped |
| fault_dom | output | 4 | Domain of the faulting entry |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor returned |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Bus error on the read |

## Verification
The bench builds the walker with its package defaults: 32-bit words, four-bit domain numbers and two-bit permission fields. These defaults are the only values the descriptor format allows. The bench memory holds ready low on some cycles and returns responses after zero to two idle cycles. This brings wait states within reach in both fetch phases, together with a second `start` pulse that lands mid-walk. The chosen descriptors cover every first- and second-level type. They include each permission quarter selected by address bits, domain modes 0 to 3 on sections and on tables, and bus errors at either level.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned DOM_W   = 4;
  localparam int unsigned AP_W    = 2;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned ACC_W   = 2;
  localparam int unsigned KIND_W  = 3;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [KIND_W-1:0] {
    F_NONE = 3'd0, F_XLAT = 3'd1, F_DOM = 3'd2, F_PERM = 3'd3, F_ABORT = 3'd4
  } fault_e;

  typedef enum logic [1:0] {PG_1K = 2'd0, PG_4K = 2'd1, PG_64K = 2'd2, PG_1M = 2'd3} pgsz_e;

  typedef struct packed {
    word_t            va;
    logic [ACC_W-1:0] acc;
    logic             user;
    word_t            ttb;
    word_t            dacr;
    logic             ext_en;
  } walk_req_t;

  function automatic word_t l1_entry_addr(word_t base, word_t v);
    return {base[31:14], v[31:20], 2'b00};
  endfunction

  function automatic word_t l2_entry_addr(word_t desc, word_t v, logic fine);
    return fine ? {desc[31:12], v[19:10], 2'b00} : {desc[31:10], v[19:12], 2'b00};
  endfunction

  function automatic logic [AP_W-1:0] dom_mode(word_t ctl, logic [DOM_W-1:0] d);
    return ctl[{d, 1'b0} +: AP_W];
  endfunction

  function automatic logic [AP_W-1:0] quarter_ap(word_t desc, logic [1:0] q);
    case (q)
      2'd0:    return desc[5:4];
      2'd1:    return desc[7:6];
      2'd2:    return desc[9:8];
      default: return desc[11:10];
    endcase
  endfunction

  // Returns {write_ok, read_ok} for a client domain.
  function automatic logic [1:0] client_rw(logic [AP_W-1:0] ap, logic user);
    case (ap)
      2'd0:    return 2'b00;
      2'd1:    return user ? 2'b00 : 2'b11;
      2'd2:    return user ? 2'b01 : 2'b11;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/pgw_l1_dec.sv
module pgw_l1_dec
  import pgw_pkg::*;
(
  input  word_t             desc,
  input  word_t             va,
  input  word_t             dacr,
  output logic [1:0]        kind,
  output logic [DOM_W-1:0]  dom,
  output logic [AP_W-1:0]   dmode,
  output logic              deny,
  output word_t             l2_addr,
  output word_t             sec_pa,
  output logic [AP_W-1:0]   sec_ap
);
  logic unused_l1;
  assign unused_l1 = ^{desc[4:2], desc[9]};

  assign kind    = desc[1:0];
  assign dom     = desc[8:5];
  assign dmode   = dom_mode(dacr, dom);
  assign deny    = ~dmode[0];
  assign l2_addr = l2_entry_addr(desc, va, kind == 2'd3);
  assign sec_pa  = {desc[31:20], va[19:0]};
  assign sec_ap  = desc[11:10];
endmodule

// File: rtl/pgw_l2_dec.sv
module pgw_l2_dec
  import pgw_pkg::*;
(
  input  word_t           desc,
  input  word_t           va,
  input  logic            fine,
  input  logic            ext_en,
  output logic            xlat,
  output word_t           pa,
  output pgsz_e           size,
  output logic [AP_W-1:0] ap
);
  logic unused_l2;
  assign unused_l2 = ^{va[31:16], desc[3:2]};

  always_comb begin
    xlat = 1'b0;
    pa   = '0;
    size = PG_4K;
    ap   = desc[5:4];
    case (desc[1:0])
      2'd0: xlat = 1'b1;
      2'd1: begin
        pa   = {desc[31:16], va[15:0]};
        size = PG_64K;
        ap   = quarter_ap(desc, va[15:14]);
      end
      2'd2: begin
        pa   = {desc[31:12], va[11:0]};
        ap   = quarter_ap(desc, va[11:10]);
      end
      default: begin
        if (fine) begin
          pa   = {desc[31:10], va[9:0]};
          size = PG_1K;
        end else if (ext_en) begin
          pa   = {desc[31:12], va[11:0]};
        end else begin
          xlat = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm
  import pgw_pkg::*;
(
  input  logic [AP_W-1:0]  ap,
  input  logic [AP_W-1:0]  dmode,
  input  logic             user,
  input  logic [ACC_W-1:0] acc,
  output logic             allow
);
  logic [1:0] rw;
  assign rw = client_rw(ap, user);

  always_comb begin
    if (dmode == 2'd3)      allow = 1'b1;
    else if (acc == 2'd0)   allow = rw[0];
    else if (acc == 2'd1)   allow = rw[1];
    else                    allow = |rw;
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] va,
  input  logic [ACC_W-1:0]  acc,
  input  logic              is_user,
  input  logic [WORD_W-1:0] ttb,
  input  logic [WORD_W-1:0] dacr,
  input  logic              ext_page_en,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] pa,
  output logic [1:0]        page_sz,
  output logic              fault,
  output logic [KIND_W-1:0] fault_kind,
  output logic [LVL_W-1:0]  fault_lvl,
  output logic [DOM_W-1:0]  fault_dom,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err
);
  typedef enum logic [2:0] {S_IDLE, S_L1REQ, S_L1WAIT, S_L2REQ, S_L2WAIT, S_FIN} st_e;

  st_e              state;
  walk_req_t        rq;
  logic [DOM_W-1:0] dom_q;
  logic [AP_W-1:0]  dmode_q;
  logic             fine_q;
  word_t            l2a_q;

  fault_e           res_kind;
  logic [LVL_W-1:0] res_lvl;
  logic [DOM_W-1:0] res_dom;
  word_t            res_pa;
  pgsz_e            res_sz;

  logic [1:0]       l1_kind;
  logic [DOM_W-1:0] l1_dom;
  logic [AP_W-1:0]  l1_dmode, sec_ap, l2_ap, perm_ap, perm_dm;
  logic             l1_deny, l2_xlat, allow;
  word_t            l1_l2addr, sec_pa, l2_pa;
  pgsz_e            l2_sz;

  // Named events for the checker
  logic l1_hit, l2_hit, dom_block;

  assign l1_hit    = (state == S_L1WAIT) && mem_rsp_valid;
  assign l2_hit    = (state == S_L2WAIT) && mem_rsp_valid;
  assign dom_block = l1_hit && !mem_rsp_err && (l1_kind != 2'd0) && l1_deny;

  pgw_l1_dec u_l1 (
    .desc(mem_rsp_data), .va(rq.va), .dacr(rq.dacr), .kind(l1_kind), .dom(l1_dom),
    .dmode(l1_dmode), .deny(l1_deny), .l2_addr(l1_l2addr), .sec_pa(sec_pa), .sec_ap(sec_ap)
  );

  pgw_l2_dec u_l2 (
    .desc(mem_rsp_data), .va(rq.va), .fine(fine_q), .ext_en(rq.ext_en),
    .xlat(l2_xlat), .pa(l2_pa), .size(l2_sz), .ap(l2_ap)
  );

  assign perm_ap = (state == S_L1WAIT) ? sec_ap : l2_ap;
  assign perm_dm = (state == S_L1WAIT) ? l1_dmode : dmode_q;

  pgw_perm u_perm (.ap(perm_ap), .dmode(perm_dm), .user(rq.user), .acc(rq.acc), .allow(allow));

  fault_e           fin_kind;
  logic             fin_now, go_l2;
  logic [LVL_W-1:0] fin_lvl;
  logic [DOM_W-1:0] fin_dom;
  word_t            fin_pa;
  pgsz_e            fin_sz;

  always_comb begin
    fin_now  = 1'b0;
    go_l2    = 1'b0;
    fin_kind = F_NONE;
    fin_lvl  = '0;
    fin_dom  = '0;
    fin_pa   = '0;
    fin_sz   = PG_1K;
    if (l1_hit) begin
      fin_now = 1'b1;
      if (mem_rsp_err) begin
        fin_kind = F_ABORT;
        fin_lvl  = 2'd1;
      end else if (l1_kind == 2'd0) begin
        fin_kind = F_XLAT;
        fin_lvl  = 2'd1;
        fin_dom  = l1_dom;
      end else if (l1_deny) begin
        fin_kind = F_DOM;
        fin_lvl  = (l1_kind == 2'd2) ? 2'd1 : 2'd2;
        fin_dom  = l1_dom;
      end else if (l1_kind == 2'd2) begin
        if (allow) begin
          fin_pa = sec_pa;
          fin_sz = PG_1M;
        end else begin
          fin_kind = F_PERM;
          fin_lvl  = 2'd1;
          fin_dom  = l1_dom;
        end
      end else begin
        fin_now = 1'b0;
        go_l2   = 1'b1;
      end
    end else if (l2_hit) begin
      fin_now = 1'b1;
      if (mem_rsp_err || l2_xlat || !allow) begin
        fin_kind = mem_rsp_err ? F_ABORT : (l2_xlat ? F_XLAT : F_PERM);
        fin_lvl  = 2'd2;
        fin_dom  = dom_q;
      end else begin
        fin_pa = l2_pa;
        fin_sz = l2_sz;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rq       <= '0;
      dom_q    <= '0;
      dmode_q  <= '0;
      fine_q   <= 1'b0;
      l2a_q    <= '0;
      res_kind <= F_NONE;
      res_lvl  <= '0;
      res_dom  <= '0;
      res_pa   <= '0;
      res_sz   <= PG_1K;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          rq.va     <= va;
          rq.acc    <= acc;
          rq.user   <= is_user;
          rq.ttb    <= ttb;
          rq.dacr   <= dacr;
          rq.ext_en <= ext_page_en;
          state     <= S_L1REQ;
        end
        S_L1REQ: if (mem_req_ready) state <= S_L1WAIT;
        S_L2REQ: if (mem_req_ready) state <= S_L2WAIT;
        S_L1WAIT, S_L2WAIT: begin
          if (go_l2) begin
            dom_q   <= l1_dom;
            dmode_q <= l1_dmode;
            fine_q  <= (l1_kind == 2'd3);
            l2a_q   <= l1_l2addr;
            state   <= S_L2REQ;
          end else if (fin_now) begin
            res_kind <= fin_kind;
            res_lvl  <= fin_lvl;
            res_dom  <= fin_dom;
            res_pa   <= fin_pa;
            res_sz   <= fin_sz;
            state    <= S_FIN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = (state != S_IDLE);
  assign done          = (state == S_FIN);
  assign mem_req_valid = (state == S_L1REQ) || (state == S_L2REQ);
  assign mem_req_addr  = (state == S_L1REQ) ? l1_entry_addr(rq.ttb, rq.va) : l2a_q;
  assign pa            = res_pa;
  assign page_sz       = res_sz;
  assign fault_kind    = res_kind;
  assign fault         = (res_kind != F_NONE);
  assign fault_lvl     = res_lvl;
  assign fault_dom     = res_dom;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker
  import pgw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [KIND_W-1:0] fault_kind,
  input logic [LVL_W-1:0]  fault_lvl,
  input logic [DOM_W-1:0]  fault_dom,
  input logic [WORD_W-1:0] pa,
  input logic [1:0]        page_sz,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [WORD_W-1:0] mem_req_addr,
  input logic              dom_block
);
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r1_req_in_walk: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> busy);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
  a_r4_no_fetch_after_deny: assert property (@(posedge clk) disable iff (!rst_n)
    dom_block |=> (!mem_req_valid && done));
  a_r4_dom_level: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind == 3'd2) |-> (fault_lvl != 2'd0));
  a_r12_abort_level: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind == 3'd4) |-> (fault_lvl == 2'd1 || fault_lvl == 2'd2));
  a_r13_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault == (fault_kind != 3'd0)));
  a_r13_clear_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (pa == '0 && page_sz == 2'd0));
  a_r13_clear_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (fault_lvl == 2'd0 && fault_dom == 4'd0));
endmodule

bind pgwalk_top pgw_checker u_chk (.*);

// File: tb/tb_pgwalk_top.sv
`timescale 1ns/1ps
module tb_pgwalk_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0, is_user = 1'b0, ext_page_en = 1'b0;
  logic [31:0] va = '0, ttb = '0, dacr = '0;
  logic [1:0]  acc = '0;
  logic        busy, done, fault;
  logic [31:0] pa, mem_req_addr;
  logic [1:0]  page_sz, fault_lvl;
  logic [2:0]  fault_kind;
  logic [3:0]  fault_dom;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  pgwalk_top dut (.*);

  logic [31:0] mem [int unsigned];
  bit          berr [int unsigned];
  int unsigned exp_q[$];
  int          checks = 0, errors = 0, walks_done = 0, cyc = 0, rsp_cnt = -1, fetch_idx = 0;
  bit          model_busy = 0, finished = 0;
  logic [31:0] rsp_addr;
  string       cur_tag = "R1";
  int unsigned e_kind, e_lvl, e_dom, e_pa, e_sz;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic bit may(int ap, int dm, bit user, int a);
    bit r, w;
    if (dm == 3) return 1;
    r = (ap == 3) || (ap == 2) || (ap == 1 && !user);
    w = (ap == 3) || ((ap == 1 || ap == 2) && !user);
    if (a == 0) return r;
    if (a == 1) return w;
    return r || w;
  endfunction

  function automatic bit rd(int unsigned a, output int unsigned d);
    exp_q.push_back(a);
    d = mem.exists(a) ? mem[a] : 0;
    return berr.exists(a);
  endfunction

  function automatic void refwalk(int unsigned v, int a, bit u, int unsigned tb, int unsigned dc, bit ex);
    int unsigned d, t, t2, dm, ap, p, sz, lvl, dom;
    e_pa = 0; e_sz = 0; dom = 0;
    if (rd((tb & 32'hFFFF_C000) | ((v >> 20) << 2), d)) begin e_kind = 4; e_lvl = 1; e_dom = 0; return; end
    t = d & 3; dom = (d >> 5) & 15; dm = (dc >> (2 * dom)) & 3;
    e_dom = dom;
    if (t == 0) begin e_kind = 1; e_lvl = 1; return; end
    if (dm == 0 || dm == 2) begin e_kind = 2; e_lvl = (t == 2) ? 1 : 2; return; end
    if (t == 2) begin
      p = (d & 32'hFFF0_0000) | (v & 32'h000F_FFFF); ap = (d >> 10) & 3; sz = 3; lvl = 1;
    end else begin
      lvl = 2;
      if (rd((t == 1) ? ((d & 32'hFFFF_FC00) | ((v >> 10) & 32'h3FC))
                      : ((d & 32'hFFFF_F000) | ((v >> 8) & 32'hFFC)), d)) begin
        e_kind = 4; e_lvl = 2; return;
      end
      t2 = d & 3;
      if (t2 == 0 || (t2 == 3 && t == 1 && !ex)) begin e_kind = 1; e_lvl = 2; return; end
      if (t2 == 1) begin p = (d & 32'hFFFF_0000) | (v & 32'hFFFF); ap = (d >> (4 + 2 * ((v >> 14) & 3))) & 3; sz = 2; end
      else if (t2 == 2) begin p = (d & 32'hFFFF_F000) | (v & 32'hFFF); ap = (d >> (4 + 2 * ((v >> 10) & 3))) & 3; sz = 1; end
      else if (t == 3) begin p = (d & 32'hFFFF_FC00) | (v & 32'h3FF); ap = (d >> 4) & 3; sz = 0; end
      else begin p = (d & 32'hFFFF_F000) | (v & 32'hFFF); ap = (d >> 4) & 3; sz = 1; end
    end
    if (!may(ap, dm, u, a)) begin e_kind = 3; e_lvl = lvl; return; end
    e_kind = 0; e_lvl = 0; e_dom = 0; e_pa = p; e_sz = sz;
  endfunction

  // Per-clock model comparison and memory responder
  always @(negedge clk) begin
    int unsigned a;
    bit rdy;
    cyc++;
    if (rst_n && !finished) begin
      chk(busy == model_busy, "R1", "busy", busy, model_busy);
      if (mem_rsp_valid) begin mem_rsp_valid <= 1'b0; mem_rsp_err <= 1'b0; end
      if (rsp_cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(rsp_addr) ? mem[rsp_addr] : 32'h0;
        mem_rsp_err   <= berr.exists(rsp_addr);
        rsp_cnt = -1;
      end else if (rsp_cnt > 0) rsp_cnt--;
      rdy = (cyc % 3) != 1;
      mem_req_ready <= rdy;
      if (mem_req_valid && !model_busy) chk(0, "R1", "request while idle", 1, 0);
      if (mem_req_valid && rdy) begin
        a = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
        chk(mem_req_addr == a, (fetch_idx == 0) ? "R2" : "R6", "fetch address", mem_req_addr, a);
        fetch_idx++;
        rsp_addr = mem_req_addr;
        rsp_cnt  = cyc % 3;
      end
      if (done) begin
        chk(model_busy, "R1", "unexpected done", 1, 0);
        chk(exp_q.size() == 0, cur_tag, "reads left unissued", exp_q.size(), 0);
        chk(fault_kind == e_kind[2:0], cur_tag, "fault kind", fault_kind, e_kind);
        chk(fault == (e_kind != 0), "R13", "fault flag", fault, e_kind != 0);
        chk(fault_lvl == e_lvl[1:0], cur_tag, "fault level", fault_lvl, e_lvl);
        chk(fault_dom == e_dom[3:0], cur_tag, "fault domain", fault_dom, e_dom);
        chk(pa == e_pa, cur_tag, "physical address", pa, e_pa);
        chk(page_sz == e_sz[1:0], cur_tag, "page size", page_sz, e_sz);
        exp_q.delete();
        model_busy = 0;
        walks_done++;
      end
    end
    if (cyc > 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL R1 watchdog: actual %0d expected done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] TTB  = 32'h0004_0000;
  localparam logic [31:0] DACR = 32'h0000_01E4; // d0=0 d1=1 d2=2 d3=3 d4=1

  function automatic int unsigned l1a(int unsigned v);
    return (TTB & 32'hFFFF_C000) | ((v >> 20) << 2);
  endfunction

  task automatic walk(string tag, int unsigned v, int a, bit u, bit ex, bit poke = 0);
    int target;
    @(negedge clk); #1;
    cur_tag = tag;
    fetch_idx = 0;
    refwalk(v, a, u, TTB, DACR, ex);
    va = v; acc = a[1:0]; is_user = u; ttb = TTB; dacr = DACR; ext_page_en = ex;
    target = walks_done + 1;
    start = 1'b1; model_busy = 1;
    @(negedge clk); #1;
    start = 1'b0;
    if (poke) begin
      // R1: second start mid-walk with different inputs must be ignored
      @(negedge clk); #1;
      va = 32'h0010_0000; acc = 2'd1; is_user = 1'b1; dacr = 32'h0; start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    while (walks_done < target) @(negedge clk);
  endtask

  initial begin
    // Section, manager domain 3, ap 0
    mem[l1a(32'h1234_5678)] = 32'hABC0_0000 | (3 << 5) | 2;
    mem[l1a(32'h0010_0000)] = 32'h5550_0000 | (0 << 5) | (3 << 10) | 2;   // dom 0
    mem[l1a(32'h0020_0000)] = 32'h0008_0800 | (2 << 5) | 1;               // coarse, dom 2
    mem[l1a(32'h0030_0000)] = 32'h0008_0400 | (4 << 5) | 1;               // coarse, dom 4 client
    mem[32'h0008_0430] = 32'h5555_0000 | (2 << 10) | 1;                    // 64K, quarter 3 ap 2
    mem[32'h0008_0434] = 32'h7777_7000 | (3 << 4) | (3 << 6) | (1 << 8) | (3 << 10) | 2;
    mem[32'h0008_0438] = 32'h9999_9000 | (1 << 4) | 3;                     // type 3 in coarse
    mem[l1a(32'h0040_0000)] = 32'h000C_0000 | (3 << 5) | 3;               // fine, dom 3
    mem[32'h000C_0008] = 32'h1234_5400 | 3;                                // 1K page
    mem[32'h000C_0050] = 32'h2468_A000 | 2;                                // 4K via fine
    mem[l1a(32'h0070_0000)] = 32'h8880_0000 | (1 << 5) | (1 << 10) | 2;   // section, client ap 1
    berr[l1a(32'h0060_0000)] = 1;
    berr[32'h0008_0428] = 1;

    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "reset idle", {busy, done}, 0);
    chk(mem_req_valid == 0, "R1", "reset no request", mem_req_valid, 0);
    chk(fault_kind == 0 && pa == 0, "R13", "reset result", fault_kind, 0);
    #1 rst_n = 1'b1;

    walk("R5", 32'h1234_5678, 0, 1, 0);          // manager bypass, section map
    walk("R4", 32'h0010_0000, 0, 0, 0);          // domain 0 on section
    walk("R4", 32'h0020_0000, 0, 0, 0);          // domain 2 on table, no L2 read
    walk("R7", 32'h0030_C123, 0, 1, 0);          // 64K, user read ok
    walk("R11", 32'h0030_C123, 1, 1, 0);         // user write refused
    walk("R11", 32'h0030_C123, 1, 0, 0);         // privileged write ok
    walk("R8", 32'h0030_D800, 0, 1, 0);          // 4K quarter 2 ap 1, user refused
    walk("R8", 32'h0030_D800, 2, 0, 0);          // privileged fetch ok
    walk("R9", 32'h0030_E000, 0, 0, 1);          // extended 4K enabled
    walk("R9", 32'h0030_E000, 0, 0, 0);          // disabled -> translation fault
    walk("R9", 32'h0040_0ABC, 1, 1, 0);          // 1K via fine
    walk("R6", 32'h0040_5321, 0, 0, 0);          // fine table to 4K
    walk("R3", 32'h0050_0000, 0, 0, 0);          // empty L1
    walk("R10", 32'h0030_F000, 0, 0, 0);         // empty L2
    walk("R12", 32'h0060_0000, 0, 0, 0);         // error on first read
    walk("R12", 32'h0030_A000, 0, 0, 0);         // error on second read
    walk("R11", 32'h0070_0000, 2, 1, 0);         // section ap 1 user fetch refused
    walk("R11", 32'h0070_0123, 2, 0, 0);         // privileged fetch allowed
    walk("R1", 32'h0030_C123, 0, 0, 0, 1);       // start while busy ignored

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule